// File: doc/BRIEF.md
# Dual-Compare 8-bit Timer/Counter

This block is a small timer/counter with two compare channels. A count enable comes either from a prescaler tick input or from an external pin. The pin is synchronised, and a rising or falling edge on it produces a one-cycle pulse. The counter steps up or down on each enabled tick. Its upper turning point is either the all-ones value or the value held in compare register 0. When it wraps, it raises an overflow request.

Each compare channel raises its own request when an enabled tick finds the counter equal to that channel's register. All requests live in one flag vector. Software clears a flag by writing a 1 to it. Each flag is ANDed with its own mask bit to form a registered interrupt output. Software programs the control, counter, mask, clear and compare registers through a single write port.

Top module: `dual_cmp_timer`

## Requirements
- R1: After synchronous reset, the count is 0x00 and all flags, masks and interrupts are 0. The control register resets to 0, which selects the prescaler source, rising edge, up count and fixed top.
- R2: In up mode, each enabled tick adds one. With no tick, the count holds. On a tick at the selected top, or at 0xFF, the next count is 0x00 and overflow flag bit 0 is set. Control bit 3 = 0 selects top 0xFF, and 1 selects compare register 0.
- R3: In down mode (control bit 2 = 1), each tick subtracts one. On a tick at 0x00, the count reloads with the selected top and flag bit 0 is set.
- R4: Consider a tick that is not suppressed while the count equals compare register i. It sets flag bit i+1 (bit 1 for channel 0, bit 2 for channel 1).
- R5: Control bit 0 = 1 takes ticks from the external pin and ignores the prescaler. Control bit 1 selects the edge: 0 for rising, 1 for falling. A pin change applied before clock edge k changes the count at edge k+2.
- R6: Writing address 3 clears every flag whose data bit is 1. A flag being set in the same cycle stays set.
- R7: Interrupt bit j equals flag bit j AND mask bit j (mask at address 2). It is valid in the same cycle as the flags.
- R8: Writing the count (address 1) loads it at the next edge, and any tick in that cycle is ignored. The first tick after the load raises no compare flag.
- R9: The write map is as follows. Address 0 holds control bits [3:0], address 1 the count, address 2 the mask, address 3 the flag clear, and address 4+i compare register i. Every write takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| presc_tick | input | 1 | Prescaler count enable |
| ext_pin | input | 1 | External count input, asynchronous |
| count_o | output | 8 | Current count |
| flags_o | output | 3 | Request flags: bit0 overflow, bit1 compare 0, bit2 compare 1 |
| irq_o | output | 3 | Masked interrupt outputs |

## Verification
Up counting is run with a sparse tick pattern, so that holding without a tick and wrapping at 0xFF can be told apart from a plain free-running count. Top taken from compare register 0 is run from both below and above that value, which separates a wrap at top from a wrap at all-ones. Down counting is tried from 1, which shows whether the reload value follows the top select. The external pin is toggled with both edge selects under a steady prescaler tick, which shows the right edge is used, the prescaler is ignored and the two-edge latency is kept. Loads that coincide with a tick or a compare value, and clears that coincide with a set, isolate the priority rules. A long mixed run with random writes is compared against the bench model every cycle.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int ADDR_W = 3;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_CTRL = 3'd0;
  localparam addr_t A_CNT  = 3'd1;
  localparam addr_t A_MASK = 3'd2;
  localparam addr_t A_FCLR = 3'd3;
  localparam int    A_CMP0 = 4;

  typedef struct packed {
    logic top_a;  // bit 3: top from compare register 0
    logic down;   // bit 2: count down
    logic fall;   // bit 1: falling edge on external pin
    logic ext;    // bit 0: external pin source
  } ctrl_t;
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic fall,
  output logic pulse
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign pulse = fall ? (prev_q & ~s2_q) : (~prev_q & s2_q);

  // R5: an edge yields a single-cycle pulse unless the edge select moved
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
    pulse |=> (!pulse || (fall != $past(fall))));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         down,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] cnt_q,
  output logic         wrap_evt,
  output logic         cmp_en
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic supp_q;
  logic at_top, at_bot, advance;

  assign at_top   = (cnt_q == top_val) || (cnt_q == MAXV);
  assign at_bot   = (cnt_q == '0);
  assign advance  = tick & ~ld;
  assign wrap_evt = advance & (down ? at_bot : at_top);
  assign cmp_en   = advance & ~supp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      supp_q <= 1'b0;
    end else if (ld) begin
      cnt_q  <= ld_val;
      supp_q <= 1'b1;
    end else if (tick) begin
      supp_q <= 1'b0;
      if (down) cnt_q <= at_bot ? top_val : cnt_q - 1'b1;
      else      cnt_q <= at_top ? '0 : cnt_q + 1'b1;
    end
  end

  // R2: without tick or load the count holds
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld) |=> $stable(cnt_q));
  // R2: up wrap at top returns to zero
  p_up_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld && !down && cnt_q == top_val) |=> (cnt_q == '0));
  // R3: down wrap at bottom reloads top
  p_down_reload_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld && down && cnt_q == '0) |=> (cnt_q == $past(top_val)));
  // R8: a load always wins
  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cnt_q == $past(ld_val)));
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set,
  input  logic          clr_we,
  input  logic [NF-1:0] clr_bits,
  input  logic          mask_we,
  input  logic [NF-1:0] mask_bits,
  output logic [NF-1:0] flags_q,
  output logic [NF-1:0] irq_q
);
  logic [NF-1:0] mask_q, flag_n, mask_n, clr_v;

  assign clr_v  = clr_we ? clr_bits : '0;
  assign flag_n = (flags_q & ~clr_v) | set;
  assign mask_n = mask_we ? mask_bits : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      mask_q  <= '0;
      irq_q   <= '0;
    end else begin
      flags_q <= flag_n;
      mask_q  <= mask_n;
      irq_q   <= flag_n & mask_n;
    end
  end

  for (genvar i = 0; i < NF; i++) begin : g_chk
    // R6: a set in the clear cycle survives
    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> flags_q[i]);
    // R6: a clear without a set drops the flag
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
      (clr_we && clr_bits[i] && !set[i]) |=> !flags_q[i]);
  end

  // R7: interrupts track flags through the mask
  p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
    irq_q == (flags_q & mask_q));
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int W     = 8,
  parameter int N_CMP = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [timer_pkg::ADDR_W-1:0]  wr_addr,
  input  logic [W-1:0]                  wr_data,
  input  logic                          presc_tick,
  input  logic                          ext_pin,
  output logic [W-1:0]                  count_o,
  output logic [N_CMP:0]                flags_o,
  output logic [N_CMP:0]                irq_o
);
  import timer_pkg::*;

  localparam int NF = N_CMP + 1;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  ctrl_t         ctrl_q;
  logic [W-1:0]  cmp_q [N_CMP];
  logic [N_CMP-1:0] match;
  logic          pulse, tick, ld, wrap_evt, cmp_en;
  logic [W-1:0]  cnt_q, top_val;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_en && wr_addr == A_CTRL) ctrl_q <= ctrl_t'(wr_data[3:0]);
  end

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst) cmp_q[i] <= '0;
      else if (wr_en && wr_addr == addr_t'(A_CMP0 + i)) cmp_q[i] <= wr_data;
    end
    assign match[i] = cmp_en & (cnt_q == cmp_q[i]);

    // R4: a live tick on an equal count raises the channel flag
    p_match_flag_r4: assert property (@(posedge clk) disable iff (rst)
      (cmp_en && cnt_q == cmp_q[i]) |=> flags_o[i+1]);
  end

  tmr_edge_det u_edge (
    .clk   (clk),
    .rst   (rst),
    .pin   (ext_pin),
    .fall  (ctrl_q.fall),
    .pulse (pulse)
  );

  assign tick    = ctrl_q.ext ? pulse : presc_tick;
  assign ld      = wr_en && (wr_addr == A_CNT);
  assign top_val = ctrl_q.top_a ? cmp_q[0] : MAXV;

  tmr_count_core #(.W(W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .ld       (ld),
    .ld_val   (wr_data),
    .down     (ctrl_q.down),
    .top_val  (top_val),
    .cnt_q    (cnt_q),
    .wrap_evt (wrap_evt),
    .cmp_en   (cmp_en)
  );

  tmr_flag_unit #(.NF(NF)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .set       ({match, wrap_evt}),
    .clr_we    (wr_en && wr_addr == A_FCLR),
    .clr_bits  (wr_data[NF-1:0]),
    .mask_we   (wr_en && wr_addr == A_MASK),
    .mask_bits (wr_data[NF-1:0]),
    .flags_q   (flags_o),
    .irq_q     (irq_o)
  );

  assign count_o = cnt_q;

  // R8: the tick after a load never compares
  p_supp_r8: assert property (@(posedge clk) disable iff (rst)
    ld |=> !cmp_en);
  // R1: reset clears the visible state
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (count_o == '0 && flags_o == '0 && irq_o == '0));
endmodule

// File: tb/sim_dual_cmp_timer.sv
module sim_dual_cmp_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       presc = 1'b0;
  logic       pin = 1'b0;
  logic [7:0] count_o;
  logic [2:0] flags_o, irq_o;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  dual_cmp_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .presc_tick(presc), .ext_pin(pin), .count_o(count_o), .flags_o(flags_o),
    .irq_o(irq_o)
  );

  // behavioural reference
  int m_cnt, m_flags, m_mask, m_ctrl, m_cmp0, m_cmp1, m_irq;
  bit m_supp, m_s1, m_s2, m_prev;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_flags = 0; m_mask = 0; m_ctrl = 0; m_cmp0 = 0; m_cmp1 = 0;
      m_irq = 0; m_supp = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      bit pulse, tk, ld;
      int top, setv, clr;
      pulse = m_ctrl[1] ? (m_prev && !m_s2) : (!m_prev && m_s2);
      tk    = m_ctrl[0] ? pulse : presc;
      top   = m_ctrl[3] ? m_cmp0 : 255;
      ld    = wr_en && wr_addr == 1;
      setv  = 0;
      if (ld) begin
        m_cnt = wr_data; m_supp = 1;
      end else if (tk) begin
        if (!m_supp) begin
          if (m_cnt == m_cmp0) setv |= 2;
          if (m_cnt == m_cmp1) setv |= 4;
        end
        m_supp = 0;
        if (!m_ctrl[2]) begin
          if (m_cnt == top || m_cnt == 255) begin m_cnt = 0; setv |= 1; end
          else m_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin m_cnt = top; setv |= 1; end
          else m_cnt = m_cnt - 1;
        end
      end
      clr = (wr_en && wr_addr == 3) ? (wr_data & 7) : 0;
      m_flags = (m_flags & ~clr & 7) | setv;
      if (wr_en && wr_addr == 0) m_ctrl = wr_data & 15;
      if (wr_en && wr_addr == 2) m_mask = wr_data & 7;
      if (wr_en && wr_addr == 4) m_cmp0 = wr_data;
      if (wr_en && wr_addr == 5) m_cmp1 = wr_data;
      m_irq = m_flags & m_mask;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk({cur_req, " count"}, count_o, m_cnt);
      chk({cur_req, " flags"}, flags_o, m_flags);
      chk({cur_req, " irq"},   irq_o,   m_irq);
    end
  end

  task automatic cyc(input bit t);
    presc = t; wr_en = 0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit t);
    wr_en = 1; wr_addr = a; wr_data = d; presc = t;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    chk("R1 reset count", count_o, 0);
    chk("R1 reset flags", flags_o, 0);
    chk("R1 reset irq", irq_o, 0);

    cur_req = "R2";
    wr(3'd2, 8'h07, 0);
    wr(3'd0, 8'h00, 0);
    for (int i = 0; i < 600; i++) cyc(i % 4 != 3);
    wr(3'd3, 8'h07, 0);
    wr(3'd1, 8'hFE, 0);
    cyc(1); chk("R2 step to FF", count_o, 8'hFF);
    cyc(0); chk("R2 hold without tick", count_o, 8'hFF);
    cyc(1); chk("R2 wrap to zero", count_o, 0);
    chk("R2 overflow flag", flags_o[0], 1);
    wr(3'd3, 8'h07, 0); chk("R6 clear all", flags_o, 0);

    wr(3'd4, 8'd9, 0);
    wr(3'd0, 8'h08, 0);
    wr(3'd1, 8'd0, 0);
    for (int i = 0; i < 40; i++) cyc(1);
    wr(3'd1, 8'd9, 0);
    cyc(1); chk("R2 wrap at compare top", count_o, 0);
    wr(3'd1, 8'd20, 0);
    for (int i = 0; i < 250; i++) cyc(1);

    cur_req = "R3";
    wr(3'd3, 8'h07, 0);
    wr(3'd0, 8'h04, 0);
    wr(3'd1, 8'd1, 0);
    cyc(1); chk("R3 down step", count_o, 0);
    cyc(1); chk("R3 reload fixed top", count_o, 8'hFF);
    chk("R3 overflow flag", flags_o[0], 1);
    wr(3'd0, 8'h0C, 0);
    wr(3'd1, 8'd0, 0);
    cyc(1); chk("R3 reload compare top", count_o, 9);
    for (int i = 0; i < 60; i++) cyc(i % 2 == 0);

    cur_req = "R4";
    wr(3'd3, 8'h07, 0);
    wr(3'd0, 8'h00, 0);
    wr(3'd5, 8'h30, 0);
    wr(3'd1, 8'h2E, 0);
    cyc(1); cyc(1);
    chk("R4 no early match", flags_o[2], 0);
    cyc(1); chk("R4 channel 1 match", flags_o[2], 1);
    chk("R4 channel 0 quiet", flags_o[1], 0);

    cur_req = "R8";
    wr(3'd3, 8'h07, 0);
    wr(3'd1, 8'h30, 0);
    cyc(1); chk("R8 match suppressed", flags_o[2], 0);
    chk("R8 count advanced", count_o, 8'h31);
    wr(3'd1, 8'h40, 1); chk("R8 load beats tick", count_o, 8'h40);

    cur_req = "R6";
    wr(3'd3, 8'h07, 0);
    wr(3'd1, 8'h2E, 0);
    cyc(1); cyc(1);
    wr(3'd3, 8'h04, 1); chk("R6 set wins over clear", flags_o[2], 1);

    cur_req = "R7";
    wr(3'd2, 8'h00, 0); chk("R7 masked off", irq_o, 0);
    wr(3'd2, 8'h04, 0); chk("R7 mask bit 2", irq_o[2], 1);

    cur_req = "R5";
    wr(3'd3, 8'h07, 0);
    wr(3'd0, 8'h01, 0);
    pin = 0;
    for (int i = 0; i < 4; i++) cyc(1);
    wr(3'd1, 8'h10, 0);
    cyc(1); cyc(1);
    c0 = count_o;
    pin = 1;
    cyc(1); cyc(1); chk("R5 rising not early", count_o, c0);
    cyc(1); chk("R5 rising counts", count_o, c0 + 1);
    for (int i = 0; i < 4; i++) cyc(1);
    chk("R5 prescaler ignored", count_o, c0 + 1);
    wr(3'd0, 8'h03, 0);
    cyc(1); cyc(1);
    c0 = count_o;
    pin = 0;
    cyc(1); cyc(1); chk("R5 falling not early", count_o, c0);
    cyc(1); chk("R5 falling counts", count_o, c0 + 1);
    for (int i = 0; i < 200; i++) begin
      if (i % 50 == 0) wr(3'd0, {6'd0, 1'b1, 1'b0} | ((i / 50) % 2 ? 8'h02 : 8'h00), 0);
      pin = ((i * 7) % 5) < 2;
      cyc(1);
    end

    cur_req = "R9";
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(0, 9) == 0) begin
        logic [2:0] a;
        logic [7:0] d;
        a = 3'($urandom_range(0, 5));
        d = 8'($urandom_range(0, 255));
        pin = 1'($urandom_range(0, 1));
        wr(a, d, 1'($urandom_range(0, 1)));
      end else begin
        pin = 1'($urandom_range(0, 1));
        cyc(1'($urandom_range(0, 1)));
      end
    end

    finish_run();
  end
endmodule